// File: doc/BRIEF.md
# Audio Serial Clock Prescaler

This block divides a fast source clock down to the clocks an audio serial port needs. A small configuration register holds an 8-bit linear divider, an extra "odd" bit that lengthens each divided period by one source cycle, and a master-clock mode bit. The divided clock has a period of twice the linear divider plus the odd bit, counted in source cycles.

In direct mode the divided clock is the bit clock and the master-clock pin stays low. In master-clock mode the divided clock leaves on the master-clock pin. The bit clock is then produced from it by a further fixed divide by 4 for 16-bit frames or by 8 for 32-bit frames. Writes that hold an illegal divider are replaced by a safe default pair as they are stored. A new setting only takes over once the period in progress has finished, so the outputs never carry a shortened pulse. Both clocks run only while the port enable is high.

Top module: `aclk_prescaler`

## Requirements
- R1: After reset the register reads back 0x0002 (divider 2, odd bit clear, direct mode), and both clock outputs are low.
- R2: The register holds the linear divider in bits [7:0], the odd bit in bit 8 and the master-clock mode bit in bit 9. A write is visible on the read-back bus on the cycle after the write edge. Bits [15:10] are not stored and read back as zero.
- R3: A write whose divider field is 0 or 1 stores divider 2 with the odd bit cleared, and keeps the written mode bit. The field is 8 bits wide, so no value above 255 can reach the register.
- R4: The divided clock repeats every 2*div+odd source cycles. Its high phase lasts div+odd cycles and its low phase lasts div cycles.
- R5: In direct mode (bit 9 = 0) the bit clock is the divided clock and the master clock stays low.
- R6: In master-clock mode (bit 9 = 1) the master clock is the divided clock. The bit clock has 50% duty and lasts 4 master-clock periods when frame32 = 0 or 8 when frame32 = 1. It rises in the same cycle as a master-clock rising edge.
- R7: While port_en is low both outputs are low from the first edge on, and the dividers are cleared. The first edge that samples port_en high starts a fresh period with the outputs high.
- R8: A register write made during a running period does not change that period. The new setting applies from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Runs the clock outputs when high |
| frame32 | input | 1 | 1 selects 32-bit frames (bit clock = master clock / 8), 0 selects 16-bit (/4) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read-back |
| mclk_out | output | 1 | Master clock |
| bclk_out | output | 1 | Bit clock |

## Verification
The divider is exercised with an even setting, an odd setting, the minimum, the maximum, and illegal divider writes. Measuring the high and low run lengths separates a wrong total ratio from a wrong split between the two phases. Master-clock runs at both frame widths, with and without the odd bit, show whether the second stage counts master-clock periods or source cycles. A write in the middle of a period, and a disable followed by a re-enable, show whether updates wait for the period boundary and whether the phase restarts.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
    localparam int DIV_W   = 8;
    localparam int REG_W   = 16;
    localparam int MIN_DIV = 2;
    localparam int DEF_DIV = 2;
    localparam int ODD_POS = 8;
    localparam int MCK_POS = 9;
    localparam int CNT_W   = DIV_W + 1;

    // stored prescaler setting; packed order matches read-back bit positions
    typedef struct packed {
        logic             mck;
        logic             odd;
        logic [DIV_W-1:0] div;
    } pre_cfg_t;

    // setting in force for the running period
    typedef struct packed {
        logic     wide;
        pre_cfg_t cfg;
    } act_cfg_t;

    localparam pre_cfg_t CFG_RESET = '{mck: 1'b0, odd: 1'b0, div: DIV_W'(DEF_DIV)};
endpackage

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
    import aclk_pkg::*;
#(
    parameter int REG_WIDTH = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_WIDTH-1:0] wr_data,
    output pre_cfg_t             cfg_q,
    output logic [REG_WIDTH-1:0] rd_data
);
    localparam int CFG_BITS = $bits(pre_cfg_t);

    pre_cfg_t cfg_d;
    pre_cfg_t cand;

    always_comb begin
        cand.div = wr_data[DIV_W-1:0];
        cand.odd = wr_data[ODD_POS];
        cand.mck = wr_data[MCK_POS];
        // legalise: a divider under the minimum falls back to the default pair
        if (cand.div < DIV_W'(MIN_DIV)) begin
            cand.div = DIV_W'(DEF_DIV);
            cand.odd = 1'b0;
        end
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data = {{(REG_WIDTH-CFG_BITS){1'b0}}, cfg_q};

    p_div_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.div >= DIV_W'(MIN_DIV));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[DIV_W-1:0] >= DIV_W'(MIN_DIV)))
        |=> (rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/aclk_div_core.sv
module aclk_div_core
    import aclk_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     frame32,
    input  pre_cfg_t cfg_in,
    output act_cfg_t act_q,
    output logic     divclk_q,
    output logic     rise_nxt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        act_cfg_t      act;
        logic          clk_o;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [CW-1:0] period;
    logic [CW-1:0] hi_len;
    logic          last;

    always_comb begin
        period = CW'({s_q.act.cfg.div, 1'b0}) + CW'(s_q.act.cfg.odd);
        hi_len = CW'(s_q.act.cfg.div) + CW'(s_q.act.cfg.odd);
        last   = (s_q.cnt == period - CW'(1));

        s_d       = s_q;
        s_d.clk_o = run && (s_q.cnt < hi_len);
        if (!run || last) begin
            // idle or period boundary: restart and pick up the stored setting
            s_d.cnt      = '0;
            s_d.act.wide = frame32;
            s_d.act.cfg  = cfg_in;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
        rise_nxt = s_d.clk_o && !s_q.clk_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt      <= '0;
            s_q.act.wide <= 1'b0;
            s_q.act.cfg  <= CFG_RESET;
            s_q.clk_o    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_q    = s_q.act;
    assign divclk_q = s_q.clk_o;

    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < period);

    p_setting_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(s_q.act));
endmodule

// File: rtl/aclk_sub_div.sv
module aclk_sub_div #(
    parameter int NARROW_LOG = 2,
    parameter int WIDE_LOG   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mck_mode,
    input  logic wide,
    input  logic rise_nxt,
    input  logic divclk_q,
    output logic bclk_q
);
    localparam int SUB_W = (WIDE_LOG > NARROW_LOG) ? WIDE_LOG : NARROW_LOG;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             bclk;
    } sub_st_t;

    sub_st_t s_d, s_q;
    logic [$clog2(SUB_W)-1:0] tap;

    always_comb begin
        tap  = wide ? $clog2(SUB_W)'(WIDE_LOG - 1) : $clog2(SUB_W)'(NARROW_LOG - 1);
        s_d  = s_q;
        if (!run || !mck_mode) begin
            // preset so the first master-clock rise lands on count zero
            s_d.sub  = '1;
            s_d.bclk = 1'b0;
        end else begin
            if (rise_nxt) begin
                s_d.sub = s_q.sub + SUB_W'(1);
            end
            s_d.bclk = ~s_d.sub[tap];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sub  <= '1;
            s_q.bclk <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk_q = s_q.bclk;

    p_bclk_rises_with_mclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_q) |-> divclk_q);

    p_sub_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mck_mode |=> !bclk_q);
endmodule

// File: rtl/aclk_prescaler.sv
module aclk_prescaler
    import aclk_pkg::*;
#(
    parameter int REG_WIDTH  = REG_W,
    parameter int NARROW_LOG = 2,
    parameter int WIDE_LOG   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_en,
    input  logic                 frame32,
    input  logic                 wr_en,
    input  logic [REG_WIDTH-1:0] wr_data,
    output logic [REG_WIDTH-1:0] rd_data,
    output logic                 mclk_out,
    output logic                 bclk_out
);
    pre_cfg_t cfg_q;
    act_cfg_t act_q;
    logic     divclk_q;
    logic     rise_nxt;
    logic     sub_bclk_q;

    aclk_cfg_reg #(.REG_WIDTH(REG_WIDTH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .rd_data (rd_data)
    );

    aclk_div_core #(.CW(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (port_en),
        .frame32  (frame32),
        .cfg_in   (cfg_q),
        .act_q    (act_q),
        .divclk_q (divclk_q),
        .rise_nxt (rise_nxt)
    );

    aclk_sub_div #(.NARROW_LOG(NARROW_LOG), .WIDE_LOG(WIDE_LOG)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (port_en),
        .mck_mode (act_q.cfg.mck),
        .wide     (act_q.wide),
        .rise_nxt (rise_nxt),
        .divclk_q (divclk_q),
        .bclk_q   (sub_bclk_q)
    );

    assign mclk_out = act_q.cfg.mck & divclk_q;
    assign bclk_out = act_q.cfg.mck ? sub_bclk_q : divclk_q;

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!bclk_out && !mclk_out));
endmodule

// File: tb/aclk_prescaler_test.sv
module aclk_prescaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic        frame32 = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        mclk_out;
    logic        bclk_out;

    int vectors = 0;
    int misses  = 0;

    always #10 clk = ~clk;

    aclk_prescaler uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .frame32(frame32),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .mclk_out(mclk_out), .bclk_out(bclk_out)
    );

    typedef struct packed {
        logic [15:0] wd;
        logic        f32;
        logic        sel_m;
        logic [15:0] rd;
        logic [15:0] hi;
        logic [15:0] lo;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h0003, 1'b0, 1'b0, 16'h0003, 16'd3,   16'd3},    // R4 even
        '{16'h0102, 1'b0, 1'b0, 16'h0102, 16'd3,   16'd2},    // R4 odd
        '{16'h0001, 1'b0, 1'b0, 16'h0002, 16'd2,   16'd2},    // R3 div 1
        '{16'h0100, 1'b0, 1'b0, 16'h0002, 16'd2,   16'd2},    // R3 div 0, odd dropped
        '{16'h0302, 1'b0, 1'b1, 16'h0302, 16'd3,   16'd2},    // R6 mclk odd
        '{16'h0202, 1'b0, 1'b0, 16'h0202, 16'd8,   16'd8},    // R6 /4
        '{16'h0202, 1'b1, 1'b0, 16'h0202, 16'd16,  16'd16},   // R6 /8
        '{16'h0302, 1'b0, 1'b0, 16'h0302, 16'd10,  16'd10},   // R6 /4 odd
        '{16'h0200, 1'b1, 1'b1, 16'h0202, 16'd2,   16'd2},    // R3 keeps mode bit
        '{16'hFC07, 1'b0, 1'b0, 16'h0007, 16'd7,   16'd7},    // R2 upper bits dropped
        '{16'h00FF, 1'b0, 1'b0, 16'h00FF, 16'd255, 16'd255}   // R4 maximum
    };

    function automatic string tag_of(int i);
        case (i)
            2, 3, 8: return "R3";
            4, 5, 6, 7: return "R6";
            9: return "R2";
            default: return "R4";
        endcase
    endfunction

    function automatic logic pick(logic sel_m);
        return sel_m ? mclk_out : bclk_out;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic run_len(input logic sel_m, input logic lvl, output int n);
        n = 0;
        while (pick(sel_m) === lvl && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_reg(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int h, l, h2, ones;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd", int'(rd_data), 16'h0002);
        check("R1 bclk", int'(bclk_out), 0);
        check("R1 mclk", int'(mclk_out), 0);
        port_en = 1'b1;
        @(negedge clk);
        run_len(1'b0, 1'b1, h);
        run_len(1'b0, 1'b0, l);
        check("R1 default hi", h, 2);
        check("R1 default lo", l, 2);
        port_en = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            port_en = 1'b0;
            frame32 = VEC[i].f32;
            write_reg(VEC[i].wd);
            @(negedge clk);
            check({tag_of(i), " rd"}, int'(rd_data), int'(VEC[i].rd));
            port_en = 1'b1;
            @(negedge clk);
            run_len(VEC[i].sel_m, 1'b1, h);
            run_len(VEC[i].sel_m, 1'b0, l);
            check({tag_of(i), " hi"}, h, int'(VEC[i].hi));
            check({tag_of(i), " lo"}, l, int'(VEC[i].lo));
            port_en = 1'b0;
            @(negedge clk);
        end

        // R5 direct mode: master clock silent while bit clock runs
        frame32 = 1'b0;
        write_reg(16'h0003);
        @(negedge clk);
        port_en = 1'b1;
        ones = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (mclk_out) ones++;
        end
        check("R5 mclk highs", ones, 0);

        // R7 disable mid-high, then restart with a full high phase
        port_en = 1'b0;
        @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        check("R7 low after disable", int'(bclk_out), 0);
        ones = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (bclk_out || mclk_out) ones++;
        end
        check("R7 idle highs", ones, 0);
        port_en = 1'b1;
        @(negedge clk);
        check("R7 restart high", int'(bclk_out), 1);
        run_len(1'b0, 1'b1, h);
        check("R7 restart hi len", h, 3);

        // R8 write during a period: current period unchanged
        port_en = 1'b0;
        @(negedge clk);
        port_en = 1'b1;
        @(negedge clk);
        write_reg(16'h0005);
        check("R2 rd after write", int'(rd_data), 16'h0005);
        run_len(1'b0, 1'b1, h2);
        check("R8 old hi", h2 + 1, 3);
        run_len(1'b0, 1'b0, l);
        check("R8 old lo", l, 3);
        run_len(1'b0, 1'b1, h);
        run_len(1'b0, 1'b0, l);
        check("R8 new hi", h, 5);
        check("R8 new lo", l, 5);
        port_en = 1'b0;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule